// File: doc/BRIEF.md
# Multiplexed-Address DRAM Cycle Sequencer

This block sits between a synchronous host and an asynchronous DRAM that is driven through row strobe, column strobe, write enable and output enable lines. The host places one read or write at a time with a valid/ready handshake. The block then puts the upper half of the cell address on a shared address bus, lowers the row strobe, switches the bus to the lower half and lowers the column strobe. It ends the cycle with a precharge gap before it accepts the next request. A read returns its data with a one-cycle done pulse. A write is signalled by the same pulse.

Every timing minimum is a parameter counted in system clocks, already rounded up by the integrator. After reset the block holds the row strobe high for a power-up pause. It then issues a train of row-strobe-only cycles before it first raises ready. A separate refresh arbiter owns the memory whenever its grant input is low. The block starts no cycle while the grant is low.

Top module: `dram_seq`

## Requirements
- R1: During reset and for T_PWR clocks after reset is released, the row, column, write and output strobes are all high, dq_oe_o is low, done_o is low and req_ready_o is low.
- R2: After the pause, exactly N_INIT initialization pulses follow. In each pulse the row strobe is low for T_RAS clocks and then high for max(T_RP, T_CP) clocks. The column strobe stays high and addr_o stays 0 throughout.
- R3: req_ready_o is high only in the idle state while grant_i is high. While it is low, a pending request starts no cycle and every strobe stays high.
- R4: The clock after a request is accepted, addr_o carries req_addr_i[21:11] (the row half) with every strobe still high. The row strobe then falls and stays low with the row half held for T_RCD clocks.
- R5: addr_o then switches to the captured req_addr_i[10:0] (the column half) one clock before the column strobe falls. It holds that value while the column strobe is low, even if req_addr_i changes after acceptance.
- R6: The column strobe stays low for exactly T_CAS clocks in each access.
- R7: The column strobe is low only while the row strobe is low. The row strobe stays low for at least T_RAS clocks per access. It rises T_HOLD = max(0, T_RAS - 1 - T_RCD - T_CAS) clocks after the column strobe rises.
- R8: After the row strobe rises, it stays high for at least max(T_RP, T_CP) clocks before the next fall, and req_ready_o stays low during that gap.
- R9: In a write, the write strobe is low and dq_oe_o is high with dq_out_o equal to the captured write data. This holds from one clock before the column strobe falls until the column strobe rises. The output strobe stays high.
- R10: In a read, the write strobe stays high, dq_oe_o stays low, and the output strobe is low exactly while the column strobe is low. rdata_o takes the value on dq_in_i in the last clock of the column-low window.
- R11: done_o is high for exactly one clock, the first clock after the row strobe rises at the end of an access. For a read, rdata_o is valid while done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Block can accept a request this clock |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ROW_W+COL_W | Cell address: row half in the upper bits, column half in the lower bits |
| req_wdata_i | input | DATA_W | Write data |
| grant_i | input | 1 | Memory granted by the refresh arbiter |
| done_o | output | 1 | One-clock access completion pulse |
| rdata_o | output | DATA_W | Read data, valid with done_o after a read |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write strobe, active low |
| oe_n_o | output | 1 | Output enable, active low |
| addr_o | output | max(ROW_W,COL_W) | Multiplexed address bus |
| dq_out_o | output | DATA_W | Data driven toward the memory |
| dq_oe_o | output | 1 | Drive enable for dq_out_o |
| dq_in_i | input | DATA_W | Data returned by the memory |

## Verification
The bench builds the block with a 20-clock power-up pause, eight initialization pulses, T_RAS=6, T_RP=3, T_CP=2, T_RCD=2 and T_CAS=2. With these values the whole power-on train can be checked clock by clock within a few hundred cycles. Because 1+T_RCD+T_CAS falls one short of T_RAS, every access also passes through the extra hold phase in which the row strobe stays low after the column strobe rises. Unequal T_RP and T_CP show that the longer of the two sets the precharge gap. A small memory model on the strobes stores writes and returns reads only while the column and output strobes are both low. Reading back through the block therefore shows whether data was driven and sampled at the right clocks.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [3:0] {
    ST_PWR,
    ST_INIT_LO,
    ST_INIT_HI,
    ST_IDLE,
    ST_ROW,
    ST_RAS,
    ST_COL,
    ST_CAS,
    ST_HOLD,
    ST_PRE
  } seq_state_t;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_seq_timer.sv
module dram_seq_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= W'(RST_VAL);
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/dram_seq_amux.sv
module dram_seq_amux #(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 11,
  parameter int DATA_W = 16,
  parameter int AW     = 11
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   capture,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic                   req_we,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic                   sel_col,
  output logic [AW-1:0]          addr_o,
  output logic                   wr_o,
  output logic [DATA_W-1:0]      wdata_o
);

  logic [COL_W-1:0] col_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q   <= '0;
      wr_o    <= 1'b0;
      wdata_o <= '0;
      addr_o  <= '0;
    end else if (capture) begin
      col_q   <= req_addr[COL_W-1:0];
      wr_o    <= req_we;
      wdata_o <= req_wdata;
      addr_o  <= AW'(req_addr[ROW_W+COL_W-1:COL_W]);
    end else if (sel_col) begin
      addr_o  <= AW'(col_q);
    end
  end

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_seq_pkg::*;
#(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 11,
  parameter int DATA_W = 16,
  parameter int T_PWR  = 10000,
  parameter int N_INIT = 8,
  parameter int T_RAS  = 3,
  parameter int T_RP   = 2,
  parameter int T_CP   = 1,
  parameter int T_RCD  = 1,
  parameter int T_CAS  = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid_i,
  output logic                       req_ready_o,
  input  logic                       req_we_i,
  input  logic [ROW_W+COL_W-1:0]     req_addr_i,
  input  logic [DATA_W-1:0]          req_wdata_i,
  input  logic                       grant_i,
  output logic                       done_o,
  output logic [DATA_W-1:0]          rdata_o,
  output logic                       ras_n_o,
  output logic                       cas_n_o,
  output logic                       we_n_o,
  output logic                       oe_n_o,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] addr_o,
  output logic [DATA_W-1:0]          dq_out_o,
  output logic                       dq_oe_o,
  input  logic [DATA_W-1:0]          dq_in_i
);

  localparam int AW     = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int T_PRE  = int'(max_u(T_RP, T_CP));
  localparam int BUSY   = 1 + T_RCD + T_CAS;
  localparam int T_HOLD = (T_RAS > BUSY) ? (T_RAS - BUSY) : 0;
  localparam int MAXT   = int'(max_u(max_u(T_PWR, T_RAS), max_u(max_u(T_PRE, T_RCD), T_CAS)));
  localparam int TW     = $clog2(MAXT + 1);
  localparam int IW     = $clog2(N_INIT + 1);

  localparam logic [TW-1:0] LD_RAS  = TW'(T_RAS - 1);
  localparam logic [TW-1:0] LD_PRE  = TW'(T_PRE - 1);
  localparam logic [TW-1:0] LD_RCD  = TW'(T_RCD - 1);
  localparam logic [TW-1:0] LD_CAS  = TW'(T_CAS - 1);
  localparam logic [TW-1:0] LD_HOLD = TW'((T_HOLD > 0) ? T_HOLD - 1 : 0);

  seq_state_t     state_q, nxt;
  logic           ld;
  logic [TW-1:0]  ld_val;
  logic           expired;
  logic [IW-1:0]  init_cnt_q;
  logic           accept;
  logic           wr_q;
  logic [DATA_W-1:0] wdata_q;

  assign req_ready_o = (state_q == ST_IDLE) && grant_i;
  assign accept      = req_valid_i && req_ready_o;

  dram_seq_timer #(.W(TW), .RST_VAL(T_PWR - 1)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ld_val),
    .expired  (expired)
  );

  dram_seq_amux #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .AW(AW)) u_amux (
    .clk       (clk),
    .rst       (rst),
    .capture   (accept),
    .req_addr  (req_addr_i),
    .req_we    (req_we_i),
    .req_wdata (req_wdata_i),
    .sel_col   (nxt == ST_COL && state_q != ST_COL),
    .addr_o    (addr_o),
    .wr_o      (wr_q),
    .wdata_o   (wdata_q)
  );

  // Sequencing: each state lasts (loaded value + 1) clocks
  always_comb begin
    nxt    = state_q;
    ld     = 1'b0;
    ld_val = '0;
    unique case (state_q)
      ST_PWR:     if (expired) begin nxt = ST_INIT_LO; ld = 1'b1; ld_val = LD_RAS; end
      ST_INIT_LO: if (expired) begin nxt = ST_INIT_HI; ld = 1'b1; ld_val = LD_PRE; end
      ST_INIT_HI: if (expired) begin
                    if (init_cnt_q == IW'(N_INIT - 1)) nxt = ST_IDLE;
                    else begin nxt = ST_INIT_LO; ld = 1'b1; ld_val = LD_RAS; end
                  end
      ST_IDLE:    if (accept) begin nxt = ST_ROW; ld = 1'b1; ld_val = '0; end
      ST_ROW:     if (expired) begin nxt = ST_RAS; ld = 1'b1; ld_val = LD_RCD; end
      ST_RAS:     if (expired) begin nxt = ST_COL; ld = 1'b1; ld_val = '0; end
      ST_COL:     if (expired) begin nxt = ST_CAS; ld = 1'b1; ld_val = LD_CAS; end
      ST_CAS:     if (expired) begin
                    ld = 1'b1;
                    if (T_HOLD > 0) begin nxt = ST_HOLD; ld_val = LD_HOLD; end
                    else            begin nxt = ST_PRE;  ld_val = LD_PRE;  end
                  end
      ST_HOLD:    if (expired) begin nxt = ST_PRE; ld = 1'b1; ld_val = LD_PRE; end
      ST_PRE:     if (expired) nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_PWR;
      init_cnt_q <= '0;
    end else begin
      state_q <= nxt;
      if (state_q == ST_INIT_HI && expired && init_cnt_q != IW'(N_INIT - 1))
        init_cnt_q <= init_cnt_q + 1'b1;
    end
  end

  // Strobes and data are registered from the next state
  logic ras_lo_d, col_ph_d;
  assign ras_lo_d = nxt inside {ST_INIT_LO, ST_RAS, ST_COL, ST_CAS, ST_HOLD};
  assign col_ph_d = nxt inside {ST_COL, ST_CAS};

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_n_o  <= 1'b1;
      cas_n_o  <= 1'b1;
      we_n_o   <= 1'b1;
      oe_n_o   <= 1'b1;
      dq_oe_o  <= 1'b0;
      dq_out_o <= '0;
      done_o   <= 1'b0;
      rdata_o  <= '0;
    end else begin
      ras_n_o  <= ~ras_lo_d;
      cas_n_o  <= ~(nxt == ST_CAS);
      we_n_o   <= ~(wr_q && col_ph_d);
      oe_n_o   <= ~(!wr_q && nxt == ST_CAS);
      dq_oe_o  <= wr_q && col_ph_d;
      dq_out_o <= (wr_q && col_ph_d) ? wdata_q : '0;
      done_o   <= (state_q inside {ST_CAS, ST_HOLD}) && nxt == ST_PRE;
      if (state_q == ST_CAS && expired && !wr_q)
        rdata_o <= dq_in_i;
    end
  end

  // Observation counters for the strobe-width checks
  logic [TW-1:0] chk_lo_cnt, chk_hi_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_lo_cnt <= '0;
      chk_hi_cnt <= '0;
    end else if (ras_n_o) begin
      chk_lo_cnt <= '0;
      if (chk_hi_cnt != TW'(MAXT)) chk_hi_cnt <= chk_hi_cnt + 1'b1;
    end else begin
      chk_hi_cnt <= '0;
      if (chk_lo_cnt != TW'(MAXT)) chk_lo_cnt <= chk_lo_cnt + 1'b1;
    end
  end

  // R7
  ras_min_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n_o) |-> chk_lo_cnt >= TW'(T_RAS));
  // R8
  pre_min_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n_o) |-> chk_hi_cnt >= TW'(T_PRE));
  // R7
  cas_in_ras_chk: assert property (@(posedge clk) disable iff (rst)
    !cas_n_o |-> !ras_n_o);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R9
  wr_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (!cas_n_o && !we_n_o) |-> (dq_oe_o && oe_n_o));
  // R10
  rd_nodrive_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_n_o |-> (!dq_oe_o && we_n_o && !cas_n_o));
  // R3
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready_o |-> (ras_n_o && cas_n_o && grant_i));

endmodule

// File: tb/sim_dram_seq.sv
module sim_dram_seq;

  localparam int ROW_W = 11, COL_W = 11, DW = 16;
  localparam int T_PWR = 20, N_INIT = 8, T_RAS = 6, T_RP = 3, T_CP = 2;
  localparam int T_RCD = 2, T_CAS = 2;
  localparam int T_PRE  = (T_RP > T_CP) ? T_RP : T_CP;
  localparam int T_HOLD = (T_RAS > 1 + T_RCD + T_CAS) ? T_RAS - 1 - T_RCD - T_CAS : 0;

  typedef struct packed {
    logic [6:0]  ctl;   // ras, cas, we, oe, dq_oe, done, ready
    logic [10:0] addr;
    logic        cdq;
    logic [15:0] dq;
    logic        crd;
    logic [15:0] rd;
    int          rq;
  } exp_t;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, req_valid = 1'b0, req_we = 1'b0, grant = 1'b1;
  logic [21:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, done, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [DW-1:0] rdata, dq_out, dq_in;
  logic [10:0] addr;

  dram_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW), .T_PWR(T_PWR), .N_INIT(N_INIT),
             .T_RAS(T_RAS), .T_RP(T_RP), .T_CP(T_CP), .T_RCD(T_RCD), .T_CAS(T_CAS)) u0 (
    .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata), .grant_i(grant),
    .done_o(done), .rdata_o(rdata), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .oe_n_o(oe_n), .addr_o(addr), .dq_out_o(dq_out), .dq_oe_o(dq_oe), .dq_in_i(dq_in));

  // Memory model driven only by the strobes
  logic [DW-1:0] mem [0:255];
  logic [DW-1:0] ref_mem [0:255];
  logic [10:0] lat_row = '0;
  logic ras_d = 1'b1, cas_d = 1'b1;
  always @(posedge clk) begin
    if (ras_d && !ras_n) lat_row <= addr;
    if (cas_d && !cas_n && !we_n) mem[{lat_row[3:0], addr[3:0]}] <= dq_out;
    ras_d <= ras_n;
    cas_d <= cas_n;
  end
  assign dq_in = (!cas_n && !oe_n) ? mem[{lat_row[3:0], addr[3:0]}] : 16'hDEAD;

  exp_t exq[$];
  exp_t cur;
  int nchk = 0, nfail = 0;
  logic armed = 1'b0, finished = 1'b0;

  always @(negedge clk) begin
    if (armed && !finished) begin
      nchk++;
      if (exq.size() == 0) begin
        if ({ras_n, cas_n, we_n, oe_n, dq_oe, done, req_ready} !== {6'b111100, grant}) begin
          nfail++;
          $display("FAIL R3 idle: ras/cas/we/oe/oe_dq/done/ready=%b expected %b",
                   {ras_n, cas_n, we_n, oe_n, dq_oe, done, req_ready}, {6'b111100, grant});
        end
      end else begin
        cur = exq.pop_front();
        if ({ras_n, cas_n, we_n, oe_n, dq_oe, done, req_ready} !== cur.ctl ||
            addr !== cur.addr || (cur.cdq && dq_out !== cur.dq) ||
            (cur.crd && rdata !== cur.rd)) begin
          nfail++;
          $display("FAIL R%0d: ctl=%b addr=%h dq=%h rd=%h expected ctl=%b addr=%h dq=%h rd=%h",
                   cur.rq, {ras_n, cas_n, we_n, oe_n, dq_oe, done, req_ready}, addr, dq_out,
                   rdata, cur.ctl, cur.addr, cur.dq, cur.rd);
        end
      end
    end
  end

  task automatic push(input logic [6:0] ctl, input logic [10:0] a, input logic cdq,
                      input logic [15:0] dq, input logic crd, input logic [15:0] rd, input int rq);
    exp_t e;
    e.ctl = ctl; e.addr = a; e.cdq = cdq; e.dq = dq; e.crd = crd; e.rd = rd; e.rq = rq;
    exq.push_back(e);
  endtask

  task automatic do_req(input logic wr, input logic [21:0] a, input logic [15:0] wd, input int holdoff);
    logic r;
    logic [10:0] row, col;
    row = a[21:11];
    col = a[10:0];
    @(posedge clk); #2;
    req_valid = 1'b1; req_we = wr; req_addr = a; req_wdata = wd;
    if (holdoff > 0) begin
      grant = 1'b0;  // R3: ready low, no cycle while grant is low
      repeat (holdoff) @(posedge clk);
      #2 grant = 1'b1;
    end
    forever begin
      @(negedge clk) r = req_ready;
      @(posedge clk);
      if (r) break;
    end
    #2;
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~wd; req_we = ~wr;
    push(7'b1111000, row, 0, '0, 0, '0, 4);                       // R4 row setup
    for (int i = 0; i < T_RCD; i++) push(7'b0111000, row, 0, '0, 0, '0, 4);  // R4
    push({2'b01, ~wr, 1'b1, wr, 2'b00}, col, wr, wd, 0, '0, 5);     // R5 / R9 column setup
    for (int i = 0; i < T_CAS; i++)
      push({2'b00, ~wr, wr, wr, 2'b00}, col, wr, wd, 0, '0, 6);     // R6 / R9 / R10
    for (int i = 0; i < T_HOLD; i++) push(7'b0111000, col, 0, '0, 0, '0, 7);  // R7
    push(7'b1111010, col, 0, '0, !wr, ref_mem[{row[3:0], col[3:0]}], 11);     // R11 / R10
    for (int i = 1; i < T_PRE; i++) push(7'b1111000, col, 0, '0, 0, '0, 8);   // R8
    if (wr) ref_mem[{row[3:0], col[3:0]}] = wd;
    while (exq.size() != 0) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'(i * 16'h0101) ^ 16'h5A5A;
      ref_mem[i] = 16'(i * 16'h0101) ^ 16'h5A5A;
    end
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      nchk++;
      if ({ras_n, cas_n, we_n, oe_n, dq_oe, done, req_ready} !== 7'b1111000) begin
        nfail++;
        $display("FAIL R1 reset: ctl=%b expected 1111000", {ras_n, cas_n, we_n, oe_n, dq_oe, done, req_ready});
      end
    end
    @(posedge clk); #2;
    rst = 1'b0;
    armed = 1'b1;
    for (int i = 0; i < T_PWR; i++) push(7'b1111000, '0, 0, '0, 0, '0, 1);   // R1 pause
    for (int p = 0; p < N_INIT; p++) begin
      for (int i = 0; i < T_RAS; i++) push(7'b0111000, '0, 0, '0, 0, '0, 2); // R2 low
      for (int i = 0; i < T_PRE; i++) push(7'b1111000, '0, 0, '0, 0, '0, 2); // R2 high
    end
    // request pending through the whole power-on sequence (R3)
    do_req(1'b1, {11'h003, 11'h005}, 16'hA1B2, 0);
    do_req(1'b0, {11'h003, 11'h005}, 16'h0, 0);        // R10 read back written word
    do_req(1'b0, {11'h00A, 11'h01C}, 16'h0, 0);        // R10 unwritten location
    do_req(1'b1, {11'h7FF, 11'h7FF}, 16'hFFFF, 3);     // R3 grant holdoff, all-ones address
    do_req(1'b1, {11'h000, 11'h000}, 16'h0000, 0);     // R5 zero address
    do_req(1'b0, {11'h7FF, 11'h7FF}, 16'h0, 0);        // R11
    do_req(1'b0, {11'h000, 11'h000}, 16'h0, 5);        // R3 / R10
    do_req(1'b1, {11'h00A, 11'h01C}, 16'h3C3C, 0);     // R9
    do_req(1'b0, {11'h00A, 11'h01C}, 16'h0, 0);        // R10
    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

endmodule